// File: doc/BRIEF.md
# Single-Accumulator Multi-Cycle Processor Core

This block is a small multi-cycle processor built around one 8-bit accumulator. Program and data share one 64-word by 10-bit RAM inside the core. Each instruction word carries a 3-bit opcode in bits [9:7], an addressing-mode bit in bit [6] and a 6-bit operand in bits [5:0]. A program counter names the word to fetch. The fetched word is latched into an instruction register, and a decoder turns its opcode into the controls for the operand multiplexer, the arithmetic unit, the accumulator and the RAM write strobe.

The RAM is filled through a preload write port while reset is held low. Reset leaves the RAM contents alone, so a second program can be preloaded after a first one has run and can read the results the first one stored. After reset is released the core runs on its own until it executes HALT. It then raises `halted` and keeps it high. The accumulator can be observed at all times on `acc_out`.

Opcodes are LOAD=000, ADD=001, SUB=010, STORE=011, JUMP=100 and HALT=111. Codes 101 and 110 do nothing. Mode 0 uses the operand as a RAM address and takes the low 8 bits of that word. Mode 1 zero-extends the 6-bit operand to 8 bits and uses it as the value.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, `halted` is 0 and `acc_out` is 0. After release, the first instruction executed is the one at word 0.
- R2: Instructions run in address order: after every instruction other than JUMP and HALT, the program counter advances by one.
- R3: With mode bit [6]=0, the value used is bits [7:0] of the RAM word addressed by operand bits [5:0].
- R4: With mode bit [6]=1, the value used is operand bits [5:0] zero-extended to 8 bits.
- R5: LOAD (000) adds the selected value to zero and writes the result into the accumulator.
- R6: ADD (001) replaces the accumulator with accumulator plus value, modulo 256.
- R7: SUB (010) replaces the accumulator with accumulator minus value, modulo 256.
- R8: STORE (011) writes the accumulator, zero-extended to 10 bits, into the RAM word named by the operand, whatever the mode bit. The accumulator does not change. The RAM is written by no other opcode.
- R9: JUMP (100) loads operand bits [5:0] into the program counter, so execution continues at that word.
- R10: HALT (111) stops fetching. `halted` goes high and stays high, and `acc_out` stays fixed until reset.
- R11: Opcodes 101 and 110 change neither the accumulator nor the RAM, and execution continues at the next word.
- R12: Every instruction takes exactly three clock cycles. A program whose HALT is the (k+1)-th instruction executed raises `halted` after exactly 3(k+1) rising edges following reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pre_we | input | 1 | Preload write strobe, used while reset is held |
| pre_addr | input | 6 | Preload word address |
| pre_data | input | 10 | Preload word value |
| halted | output | 1 | High once HALT has executed, until reset |
| acc_out | output | 8 | Accumulator contents |

## Verification
A directed program (load two stored words, add them, store the sum, halt) is followed by a second program that loads the stored word back. This separates a correct STORE from a correct ADD. Further directed programs set immediate mode against address mode for the same operand, push SUB and ADD past the 8-bit wrap in each direction, jump over an instruction, and run the unused opcodes to show that they neither change the accumulator nor write the RAM. Constrained-random programs of LOAD, ADD, SUB and STORE with random modes and operands are then scored against a bench model of the accumulator and memory. The number of cycles until halt is checked for every program, which catches a wrong state count or a wrong PC step.

// File: rtl/acc_cpu_pkg.sv
// Package: shared sizes, opcode encoding, sequencer states and the decoded
// control bundle for the accumulator core.
// Assumes DATA_W >= ADDR_W so that an immediate operand fits in a data value.
package acc_cpu_pkg;

    parameter int ADDR_W = 6;
    parameter int DATA_W = 8;
    parameter int OP_W   = 3;
    localparam int WORD_W = OP_W + 1 + ADDR_W;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 3'b000,
        OP_ADD   = 3'b001,
        OP_SUB   = 3'b010,
        OP_STORE = 3'b011,
        OP_JUMP  = 3'b100,
        OP_HALT  = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2,
        ST_STOP   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic sel_imm;    // operand mux: 1 = immediate, 0 = RAM word
        logic left_zero;  // ALU left input forced to zero
        logic sub;        // ALU subtracts instead of adds
        logic acc_we;     // accumulator takes the ALU result
        logic ram_we;     // accumulator is written to RAM
        logic pc_load;    // program counter takes the operand
        logic halt;       // stop sequencing
    } ctrl_t;

endpackage

// File: rtl/acc_cpu_ram.sv
// Module: acc_cpu_ram
// Single-port-write, single-port-read word memory with a registered read.
// Holds both the program and its data. It has no reset: contents survive
// reset of the core.
module acc_cpu_ram
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Write port: store one word when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read port: registered read, so data appears one cycle after the address.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/acc_cpu_decode.sv
// Module: acc_cpu_decode
// Turns the opcode and mode bit of the latched instruction into the control
// bundle. Opcodes that have no entry decode to all-inactive (no operation).
module acc_cpu_decode
    import acc_cpu_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic            mode,
    output ctrl_t           ctrl
);

    // Decode: one branch per supported opcode.
    always_comb begin
        ctrl         = '0;
        ctrl.sel_imm = mode;
        case (opcode)
            OP_LOAD: begin
                ctrl.acc_we    = 1'b1;
                ctrl.left_zero = 1'b1;
            end
            OP_ADD: begin
                ctrl.acc_we = 1'b1;
            end
            OP_SUB: begin
                ctrl.acc_we = 1'b1;
                ctrl.sub    = 1'b1;
            end
            OP_STORE: begin
                ctrl.ram_we = 1'b1;
            end
            OP_JUMP: begin
                ctrl.pc_load = 1'b1;
            end
            OP_HALT: begin
                ctrl.halt = 1'b1;
            end
            default: begin
                ctrl.acc_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/acc_cpu_alu.sv
// Module: acc_cpu_alu
// Two-input adder/subtractor with wraparound modulo 2**DATA_W.
module acc_cpu_alu
    import acc_cpu_pkg::*;
(
    input  logic [DATA_W-1:0] left,
    input  logic [DATA_W-1:0] right,
    input  logic              sub,
    output logic [DATA_W-1:0] result
);

    // Arithmetic: add or subtract, keeping only the low DATA_W bits.
    always_comb begin
        if (sub) begin
            result = left - right;
        end else begin
            result = left + right;
        end
    end

endmodule

// File: rtl/acc_cpu.sv
// Module: acc_cpu (top)
// Multi-cycle accumulator processor. Each instruction takes three states:
// FETCH puts the PC on the RAM read address; DECODE latches the fetched word
// into the instruction register and reads the word its operand names; EXEC
// updates the accumulator, RAM, PC or halt flag. Assumes the preload port is
// used only while rst_n is low; the preload write takes priority over a core
// write.
module acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [WORD_W-1:0] pre_data,
    output logic              halted,
    output logic [DATA_W-1:0] acc_out
);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [WORD_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    logic              halted_q;

    logic [WORD_W-1:0] ram_rdata;
    logic [ADDR_W-1:0] ram_raddr;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [WORD_W-1:0] ram_wdata;

    logic [OP_W-1:0]   ir_opcode;
    logic              ir_mode;
    logic [ADDR_W-1:0] ir_operand;
    ctrl_t             ctrl;

    logic [DATA_W-1:0] sel_value;
    logic [DATA_W-1:0] alu_left;
    logic [DATA_W-1:0] alu_result;
    logic              in_exec;
    logic              core_we;

    // Instruction fields.
    assign ir_opcode  = ir_q[WORD_W-1 -: OP_W];
    assign ir_mode    = ir_q[ADDR_W];
    assign ir_operand = ir_q[ADDR_W-1:0];
    assign in_exec    = (state_q == ST_EXEC);
    assign core_we    = in_exec && ctrl.ram_we;

    // Read address: PC while fetching, the fetched word's operand while decoding.
    always_comb begin
        if (state_q == ST_DECODE) begin
            ram_raddr = ram_rdata[ADDR_W-1:0];
        end else begin
            ram_raddr = pc_q;
        end
    end

    // Write port mux: preload first, otherwise the STORE path.
    always_comb begin
        ram_we = pre_we || core_we;
        if (pre_we) begin
            ram_waddr = pre_addr;
            ram_wdata = pre_data;
        end else begin
            ram_waddr = ir_operand;
            ram_wdata = {{(WORD_W-DATA_W){1'b0}}, acc_q};
        end
    end

    // Operand mux and ALU left input.
    always_comb begin
        if (ctrl.sel_imm) begin
            sel_value = {{(DATA_W-ADDR_W){1'b0}}, ir_operand};
        end else begin
            sel_value = ram_rdata[DATA_W-1:0];
        end
        alu_left = ctrl.left_zero ? '0 : acc_q;
    end

    acc_cpu_ram u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    acc_cpu_decode u_decode (
        .opcode (ir_opcode),
        .mode   (ir_mode),
        .ctrl   (ctrl)
    );

    acc_cpu_alu u_alu (
        .left   (alu_left),
        .right  (sel_value),
        .sub    (ctrl.sub),
        .result (alu_result)
    );

    // Sequencer: three states per instruction, a sticky stop state after HALT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_FETCH;
            pc_q     <= '0;
            ir_q     <= '0;
            acc_q    <= '0;
            halted_q <= 1'b0;
        end else begin
            case (state_q)
                ST_FETCH: begin
                    state_q <= ST_DECODE;
                end
                ST_DECODE: begin
                    ir_q    <= ram_rdata;
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (ctrl.acc_we) begin
                        acc_q <= alu_result;
                    end
                    if (ctrl.halt) begin
                        halted_q <= 1'b1;
                        state_q  <= ST_STOP;
                    end else begin
                        state_q <= ST_FETCH;
                        if (ctrl.pc_load) begin
                            pc_q <= ir_operand;
                        end else begin
                            pc_q <= pc_q + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    state_q <= ST_STOP;
                end
                default: begin
                    state_q <= ST_FETCH;
                end
            endcase
        end
    end

    assign halted  = halted_q;
    assign acc_out = acc_q;

endmodule

// File: rtl/acc_cpu_chk.sv
// Module: acc_cpu_chk
// Property checker for acc_cpu, attached by bind. It watches the ports and
// the sequencer state, PC, instruction fields and core write strobe.
module acc_cpu_chk
    import acc_cpu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              halted,
    input logic [DATA_W-1:0] acc_out,
    input logic [ADDR_W-1:0] pc_q,
    input logic              in_exec,
    input logic [OP_W-1:0]   ir_opcode,
    input logic [ADDR_W-1:0] ir_operand,
    input logic              core_we
);

    AST_PC_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> pc_q == '0); // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && ir_opcode != OP_JUMP && ir_opcode != OP_HALT)
        |=> pc_q == $past(pc_q) + 1'b1); // R2

    AST_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        core_we |-> (in_exec && ir_opcode == OP_STORE)); // R8

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && ir_opcode == OP_JUMP) |=> pc_q == $past(ir_operand)); // R9

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R10

    AST_HALT_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(acc_out)); // R10

    AST_NOP_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && (ir_opcode == 3'b101 || ir_opcode == 3'b110))
        |=> $stable(acc_out)); // R11

endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .halted     (halted),
    .acc_out    (acc_out),
    .pc_q       (pc_q),
    .in_exec    (in_exec),
    .ir_opcode  (ir_opcode),
    .ir_operand (ir_operand),
    .core_we    (core_we)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre_we = 1'b0;
    logic [5:0] pre_addr = '0;
    logic [9:0] pre_data = '0;
    logic       halted;
    logic [7:0] acc_out;

    int checks = 0;
    int fails  = 0;

    bit [9:0] mdl [64];

    always #10 clk = ~clk;

    acc_cpu u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data),
        .halted   (halted),
        .acc_out  (acc_out)
    );

    function automatic bit [9:0] enc(bit [2:0] op, bit mode, bit [5:0] opnd);
        return {op, mode, opnd};
    endfunction

    function automatic bit [7:0] wrap_add(bit [7:0] a, bit [7:0] b);
        return a + b;
    endfunction

    function automatic bit [7:0] wrap_sub(bit [7:0] a, bit [7:0] b);
        return a - b;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic poke(int addr, bit [9:0] data);
        pre_we   = 1'b1;
        pre_addr = addr[5:0];
        pre_data = data;
        @(negedge clk);
        pre_we   = 1'b0;
        mdl[addr] = data;
    endtask

    task automatic clear_ram();
        for (int a = 0; a < 64; a++) poke(a, 10'd0);
    endtask

    task automatic run(output int edges);
        edges = 0;
        rst_n = 1'b1;
        while (!halted && edges < 500) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        bit [7:0] hold;
        void'($urandom(32'd2024));

        // Reset state
        hold_reset();
        check("R1 halted in reset", halted, 0);
        check("R1 acc in reset", acc_out, 0);

        // Directed: LOAD 13, ADD 14, STORE 15, HALT
        clear_ram();
        poke(0, enc(3'b000, 0, 6'd13));
        poke(1, enc(3'b001, 0, 6'd14));
        poke(2, enc(3'b011, 0, 6'd15));
        poke(3, enc(3'b111, 0, 6'd0));
        poke(13, 10'd25);
        poke(14, 10'd30);
        run(n);
        check("R6 sum in acc", acc_out, wrap_add(8'd25, 8'd30));
        check("R10 halted", halted, 1);
        check("R12 cycles for 4 instr", n, 12);
        check("R2 sequential order", acc_out, 55);
        hold = acc_out;
        repeat (10) @(negedge clk);
        check("R10 halted sticky", halted, 1);
        check("R10 acc frozen", acc_out, hold);

        // Read back word 15 with a second program (RAM survives reset)
        hold_reset();
        poke(0, enc(3'b000, 0, 6'd15));
        poke(1, enc(3'b111, 0, 6'd0));
        run(n);
        check("R8 stored word", acc_out, 55);
        check("R1 restart at word 0", n, 6);

        // Address mode versus immediate mode on the same operand
        hold_reset();
        clear_ram();
        poke(0, enc(3'b000, 0, 6'd5));
        poke(1, enc(3'b111, 0, 6'd0));
        poke(5, 10'h3C8);
        run(n);
        check("R3 address mode low 8 bits", acc_out, 8'hC8);
        hold_reset();
        poke(0, enc(3'b000, 1, 6'd5));
        poke(1, enc(3'b001, 1, 6'd63));
        poke(2, enc(3'b111, 0, 6'd0));
        run(n);
        check("R4 R5 immediate load/add", acc_out, 68);

        // Wraparound both ways
        hold_reset();
        poke(0, enc(3'b000, 1, 6'd3));
        poke(1, enc(3'b010, 1, 6'd5));
        poke(2, enc(3'b111, 0, 6'd0));
        run(n);
        check("R7 sub wrap", acc_out, wrap_sub(8'd3, 8'd5));
        hold_reset();
        poke(20, 10'd200);
        poke(0, enc(3'b000, 0, 6'd20));
        poke(1, enc(3'b001, 0, 6'd20));
        poke(2, enc(3'b111, 0, 6'd0));
        run(n);
        check("R6 add wrap", acc_out, wrap_add(8'd200, 8'd200));

        // Jump over an instruction
        hold_reset();
        clear_ram();
        poke(0, enc(3'b000, 1, 6'd1));
        poke(1, enc(3'b100, 0, 6'd4));
        poke(2, enc(3'b001, 1, 6'd10));
        poke(3, enc(3'b111, 0, 6'd0));
        poke(4, enc(3'b001, 1, 6'd2));
        poke(5, enc(3'b111, 0, 6'd0));
        run(n);
        check("R9 jump target", acc_out, 3);
        check("R9 R12 jump cycles", n, 12);

        // Unused opcodes do nothing
        hold_reset();
        clear_ram();
        poke(0, enc(3'b000, 1, 6'd7));
        poke(1, enc(3'b101, 1, 6'd9));
        poke(2, enc(3'b110, 0, 6'd30));
        poke(3, enc(3'b111, 0, 6'd0));
        run(n);
        check("R11 nop acc", acc_out, 7);
        check("R11 nop cycles", n, 12);
        hold_reset();
        poke(0, enc(3'b000, 0, 6'd30));
        poke(1, enc(3'b111, 0, 6'd0));
        run(n);
        check("R11 nop no RAM write", acc_out, 0);

        // Constrained random programs against the bench model
        for (int t = 0; t < 40; t++) begin
            int len;
            bit [7:0] acc;
            hold_reset();
            clear_ram();
            for (int a = 32; a < 64; a++) poke(a, 10'($urandom_range(0, 1023)));
            len = $urandom_range(1, 20);
            acc = 8'd0;
            for (int i = 0; i < len; i++) begin
                bit [2:0] op;
                bit       md;
                bit [5:0] od;
                bit [7:0] v;
                op = 3'($urandom_range(0, 3));
                md = 1'($urandom_range(0, 1));
                if (md && op != 3'b011) od = 6'($urandom_range(0, 63));
                else od = 6'($urandom_range(32, 63));
                poke(i, enc(op, md, od));
                v = md ? 8'(od) : mdl[od][7:0];
                case (op)
                    3'b000: acc = wrap_add(8'd0, v);
                    3'b001: acc = wrap_add(acc, v);
                    3'b010: acc = wrap_sub(acc, v);
                    default: mdl[od] = {2'b00, acc};
                endcase
            end
            poke(len, enc(3'b111, 0, 6'd0));
            run(n);
            check("R3 R5 R6 R7 R8 random acc", acc_out, acc);
            check("R12 random cycles", n, 3 * (len + 1));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule